// File: doc/BRIEF.md
# Lane-Parallel Half-Precision Multiply-Extended Unit

This block multiplies two 128-bit vectors of IEEE-754 binary16 values lane by lane. It is the extended form of a floating-point multiply. An ordinary multiply returns the default NaN when zero meets infinity. This unit returns a signed 2.0 in that case instead. Every other operand pair follows normal IEEE multiplication with round-to-nearest-even and gradual underflow.

A request carries both source vectors and a width select. Vector mode runs 4 or 8 lanes. Scalar mode runs lane 0 only, and a merge control decides whether the untouched upper bits come from the first source or are zero. A per-exception trap-enable mask sends each raised exception either to a status flag output or to a trap request output. The result and the exception bits are registered and appear one clock after the request.

Top module: `fmx_unit`

## Requirements
- R1: Lane e occupies bits [16e+15:16e] of each vector. Each active lane multiplies the same-index elements of srcA and srcB independently of the other lanes, and rounds finite results to nearest with ties to even.
- R2: When one lane operand is ±0 and the other is ±infinity, the lane result is 2.0 (0x4000), with bit 15 set exactly when the operand signs differ. No exception is raised.
- R3: A NaN operand gives a quiet NaN. If srcA's element is a NaN, the result is that element with bit 9 forced to 1; otherwise it is srcB's element with bit 9 forced to 1. A signalling NaN (exponent all ones, fraction nonzero, bit 9 clear) in either operand raises invalid.
- R4: Infinity times a nonzero value gives an infinity, and zero times a finite value gives a zero, each with the XOR of the operand signs. No exception is raised.
- R5: A rounded magnitude beyond the largest finite value gives a signed infinity and raises overflow and inexact.
- R6: Subnormal operands and results are handled exactly with gradual underflow. Underflow is raised when the exponent before rounding lies below the normal range and the result is inexact. An exact tiny result raises no underflow.
- R7: In vector mode, wideSel=0 computes lanes 0-3 and forces bits 127:64 to zero; wideSel=1 computes all 8 lanes.
- R8: In scalar mode only lane 0 is computed. Bits 127:16 are zero when mergeEn=0 and copy srcA[127:16] when mergeEn=1. mergeEn has no effect in vector mode.
- R9: Exception bit positions are 0 invalid, 1 overflow, 2 underflow, 3 inexact. Each bit is the OR over active lanes only.
- R10: For each exception i, trapEn[i]=1 reports it on excTrap[i] and clears excFlags[i]; trapEn[i]=0 reports it on excFlags[i] and clears excTrap[i].
- R11: rspValid rises exactly one clock after reqValid. result, excFlags and excTrap hold their values between requests. Reset clears all outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Request strobe; operands and controls sampled this cycle |
| srcA | input | 128 | First source vector, eight binary16 lanes |
| srcB | input | 128 | Second source vector |
| wideSel | input | 1 | Vector width: 0 = 4 lanes, 1 = 8 lanes |
| scalarMode | input | 1 | 1 = compute lane 0 only |
| mergeEn | input | 1 | In scalar mode, keep srcA's upper bits |
| trapEn | input | 4 | Per-exception trap enable |
| rspValid | output | 1 | Result valid, one clock after a request |
| result | output | 128 | Packed product vector |
| excFlags | output | 4 | Exceptions reported as status |
| excTrap | output | 4 | Exceptions reported as trap requests |

## Verification
The bench targets zero times infinity in all four sign combinations. A design that treated this as an ordinary multiply would return 0x7E00 and raise invalid. It covers signalling and quiet NaNs on each side, where swapped priority or a missed quieting shows up as a wrong payload or a missing invalid. It covers halfway cases both in the normal range and at the subnormal floor, which expose truncation or round-half-up as an off-by-one fraction, along with an exactly tiny product that must not raise underflow. It also drives sNaNs into inactive lanes, runs scalar mode with merge on and off, and runs vector mode with merge set, so that leaking flags or misplaced upper bits show up at the result port.

// File: rtl/fmx_pkg.sv
package fmx_pkg;
  localparam int HALF_W    = 16;
  localparam int EXP_W     = 5;
  localparam int FRAC_W    = 10;
  localparam int MAN_W     = FRAC_W + 1;
  localparam int PROD_W    = 2 * MAN_W;
  localparam int EXP_BIAS  = 15;
  localparam int NUM_LANES = 8;
  localparam int FLAG_N    = 4;

  localparam int FLG_INV = 0;
  localparam int FLG_OVF = 1;
  localparam int FLG_UNF = 2;
  localparam int FLG_INX = 3;

  typedef logic [FLAG_N-1:0] excVec_t;

  typedef struct packed {
    logic                 load;
    logic                 keepUpper;
    logic [NUM_LANES-1:0] laneEn;
  } ctrlStrobe_t;
endpackage

// File: rtl/fmx_lane.sv
module fmx_lane
  import fmx_pkg::*;
(
  input  logic [HALF_W-1:0] opA,
  input  logic [HALF_W-1:0] opB,
  output logic [HALF_W-1:0] prod,
  output excVec_t           exc
);
  localparam logic [EXP_W-1:0] EXP_MAX = '1;
  localparam int LZ_W = $clog2(PROD_W);

  logic             sgnA, sgnB, sgnR;
  logic [EXP_W-1:0] expA, expB, effA, effB;
  logic [FRAC_W-1:0] frA, frB;
  logic nanA, nanB, sigA, sigB, infA, infB, zeroA, zeroB;

  logic [MAN_W-1:0]  manA, manB, manKeep;
  logic [PROD_W-1:0] prodRaw, prodNorm, prodSh;
  logic [LZ_W-1:0]   lz;
  logic              lzDone;
  logic signed [7:0] biasExp;
  logic [7:0]        shAmt;
  logic              lostBits, guardB, stickyB, rndUp, isTiny;
  logic [MAN_W:0]    manRnd;
  logic [5:0]        expOut;

  always_comb begin
    sgnA = opA[HALF_W-1];
    sgnB = opB[HALF_W-1];
    sgnR = sgnA ^ sgnB;
    expA = opA[HALF_W-2:FRAC_W];
    expB = opB[HALF_W-2:FRAC_W];
    frA  = opA[FRAC_W-1:0];
    frB  = opB[FRAC_W-1:0];
    nanA  = (expA == EXP_MAX) && (frA != '0);
    nanB  = (expB == EXP_MAX) && (frB != '0);
    sigA  = nanA && !frA[FRAC_W-1];
    sigB  = nanB && !frB[FRAC_W-1];
    infA  = (expA == EXP_MAX) && (frA == '0);
    infB  = (expB == EXP_MAX) && (frB == '0);
    zeroA = (expA == '0) && (frA == '0);
    zeroB = (expB == '0) && (frB == '0);
  end

  // Finite datapath: integer significand product, normalise, denormalise
  always_comb begin
    manA = {|expA, frA};
    manB = {|expB, frB};
    effA = (expA == '0) ? EXP_W'(1) : expA;
    effB = (expB == '0) ? EXP_W'(1) : expB;
    prodRaw = manA * manB;

    lz = '0;
    lzDone = 1'b0;
    for (int i = PROD_W-1; i >= 0; i--) begin
      if (!lzDone && prodRaw[i]) begin
        lz = LZ_W'(PROD_W-1-i);
        lzDone = 1'b1;
      end
    end
    prodNorm = prodRaw << lz;

    biasExp = $signed({3'b000, effA}) + $signed({3'b000, effB})
            - $signed({{(8-LZ_W){1'b0}}, lz}) - 8'sd14;
    isTiny = (biasExp < 8'sd1);
    shAmt  = 8'(8'sd1 - biasExp);

    if (!isTiny) begin
      prodSh   = prodNorm;
      lostBits = 1'b0;
    end else if (shAmt >= 8'(PROD_W)) begin
      prodSh   = '0;
      lostBits = |prodNorm;
    end else begin
      prodSh   = prodNorm >> shAmt;
      lostBits = |(prodNorm & ((PROD_W'(1) << shAmt) - PROD_W'(1)));
    end

    manKeep = prodSh[PROD_W-1 -: MAN_W];
    guardB  = prodSh[PROD_W-1-MAN_W];
    stickyB = (|prodSh[PROD_W-2-MAN_W:0]) | lostBits;
    rndUp   = guardB & (stickyB | manKeep[0]);
    manRnd  = {1'b0, manKeep} + (MAN_W+1)'(rndUp);
    expOut  = manRnd[MAN_W] ? (biasExp[5:0] + 6'd1) : biasExp[5:0];
  end

  // Special-value selection and packing
  always_comb begin
    prod = '0;
    exc  = '0;
    if (nanA || nanB) begin
      prod = nanA ? opA : opB;
      prod[FRAC_W-1] = 1'b1;
      exc[FLG_INV] = sigA | sigB;
    end else if ((zeroA && infB) || (infA && zeroB)) begin
      prod = {sgnR, 15'h4000};
    end else if (infA || infB) begin
      prod = {sgnR, EXP_MAX, {FRAC_W{1'b0}}};
    end else if (zeroA || zeroB) begin
      prod = {sgnR, {(HALF_W-1){1'b0}}};
    end else if (isTiny) begin
      prod = {sgnR, {(EXP_W-1){1'b0}}, manRnd[MAN_W-1:0]};
      exc[FLG_UNF] = guardB | stickyB;
      exc[FLG_INX] = guardB | stickyB;
    end else if (expOut >= 6'(EXP_MAX)) begin
      prod = {sgnR, EXP_MAX, {FRAC_W{1'b0}}};
      exc[FLG_OVF] = 1'b1;
      exc[FLG_INX] = 1'b1;
    end else begin
      prod = {sgnR, expOut[EXP_W-1:0],
              manRnd[MAN_W] ? manRnd[FRAC_W:1] : manRnd[FRAC_W-1:0]};
      exc[FLG_INX] = guardB | stickyB;
    end
  end
endmodule

// File: rtl/fmx_ctrl.sv
module fmx_ctrl
  import fmx_pkg::*;
#(
  parameter int LANES = NUM_LANES
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        wideSel,
  input  logic        scalarMode,
  input  logic        mergeEn,
  output ctrlStrobe_t strb,
  output logic        rspValid
);
  localparam int HALF_LANES = LANES / 2;

  always_comb begin
    strb.load      = reqValid;
    strb.keepUpper = scalarMode & mergeEn;
    if (scalarMode)
      strb.laneEn = LANES'(1);
    else if (wideSel)
      strb.laneEn = '1;
    else
      strb.laneEn = {{(LANES-HALF_LANES){1'b0}}, {HALF_LANES{1'b1}}};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rspValid <= 1'b0;
    else       rspValid <= reqValid;
  end

  AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid);  // R11
  AST_NO_RSP_WITHOUT_REQ: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !rspValid);  // R11
endmodule

// File: rtl/fmx_datapath.sv
module fmx_datapath
  import fmx_pkg::*;
#(
  parameter int LANES = NUM_LANES
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  ctrlStrobe_t             strb,
  input  logic [LANES*HALF_W-1:0] srcA,
  input  logic [LANES*HALF_W-1:0] srcB,
  input  logic [FLAG_N-1:0]       trapEn,
  output logic [LANES*HALF_W-1:0] result,
  output logic [FLAG_N-1:0]       excFlags,
  output logic [FLAG_N-1:0]       excTrap
);
  localparam int DATA_W = LANES * HALF_W;

  logic [HALF_W-1:0] laneProd [LANES];
  excVec_t           laneExc  [LANES];
  logic [DATA_W-1:0] nextRes;
  excVec_t           excAll;

  for (genvar l = 0; l < LANES; l++) begin : gLane
    fmx_lane uLane (
      .opA  (srcA[l*HALF_W +: HALF_W]),
      .opB  (srcB[l*HALF_W +: HALF_W]),
      .prod (laneProd[l]),
      .exc  (laneExc[l])
    );
  end

  always_comb begin
    nextRes = '0;
    excAll  = '0;
    for (int l = 0; l < LANES; l++) begin
      if (strb.laneEn[l]) begin
        nextRes[l*HALF_W +: HALF_W] = laneProd[l];
        excAll = excAll | laneExc[l];
      end else if (strb.keepUpper) begin
        nextRes[l*HALF_W +: HALF_W] = srcA[l*HALF_W +: HALF_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      result   <= '0;
      excFlags <= '0;
      excTrap  <= '0;
    end else if (strb.load) begin
      result   <= nextRes;
      excFlags <= excAll & ~trapEn;
      excTrap  <= excAll & trapEn;
    end
  end

  AST_ZERO_INF_TWO: assert property (@(posedge clk) disable iff (!rstN)
    (strb.load && strb.laneEn[0] && srcA[14:0] == 15'h0 && srcB[14:0] == 15'h7C00)
    |=> result[15:0] == {$past(srcA[15] ^ srcB[15]), 15'h4000});  // R2
  AST_NARROW_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (strb.load && !strb.laneEn[LANES-1] && !strb.keepUpper)
    |=> result[DATA_W-1:DATA_W/2] == '0);  // R7
  AST_SCALAR_MERGE: assert property (@(posedge clk) disable iff (!rstN)
    (strb.load && strb.keepUpper)
    |=> result[DATA_W-1:HALF_W] == $past(srcA[DATA_W-1:HALF_W]));  // R8
  AST_TRAP_ROUTE: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> ((excTrap & ~$past(trapEn)) == '0 && (excFlags & $past(trapEn)) == '0));  // R10
  AST_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strb.load |=> $stable(result) && $stable(excFlags));  // R11
endmodule

// File: rtl/fmx_unit.sv
module fmx_unit
  import fmx_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         reqValid,
  input  logic [127:0] srcA,
  input  logic [127:0] srcB,
  input  logic         wideSel,
  input  logic         scalarMode,
  input  logic         mergeEn,
  input  logic [3:0]   trapEn,
  output logic         rspValid,
  output logic [127:0] result,
  output logic [3:0]   excFlags,
  output logic [3:0]   excTrap
);
  ctrlStrobe_t strb;

  fmx_ctrl #(.LANES(NUM_LANES)) uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .wideSel    (wideSel),
    .scalarMode (scalarMode),
    .mergeEn    (mergeEn),
    .strb       (strb),
    .rspValid   (rspValid)
  );

  fmx_datapath #(.LANES(NUM_LANES)) uData (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .srcA     (srcA),
    .srcB     (srcB),
    .trapEn   (trapEn),
    .result   (result),
    .excFlags (excFlags),
    .excTrap  (excTrap)
  );
endmodule

// File: tb/fmx_unit_test.sv
module fmx_unit_test;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         reqValid = 1'b0;
  logic [127:0] srcA = '0, srcB = '0;
  logic         wideSel = 1'b0, scalarMode = 1'b0, mergeEn = 1'b0;
  logic [3:0]   trapEn = '0;
  logic         rspValid;
  logic [127:0] result;
  logic [3:0]   excFlags, excTrap;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  fmx_unit uut (.*);

  // {a, b, expected, flags}; flags: [0] inv [1] ovf [2] unf [3] inx
  localparam int NV = 24;
  localparam logic [51:0] VEC [NV] = '{
    {16'h3C00, 16'h4000, 16'h4000, 4'h0},  // R1
    {16'h3E00, 16'h3E00, 16'h4080, 4'h0},  // R1
    {16'hC200, 16'h3800, 16'hBE00, 4'h0},  // R1
    {16'h0000, 16'h7C00, 16'h4000, 4'h0},  // R2
    {16'h8000, 16'h7C00, 16'hC000, 4'h0},  // R2
    {16'hFC00, 16'h8000, 16'h4000, 4'h0},  // R2
    {16'h7C00, 16'h3C00, 16'h7C00, 4'h0},  // R4
    {16'hFC00, 16'h3C00, 16'hFC00, 4'h0},  // R4
    {16'h0000, 16'hBC00, 16'h8000, 4'h0},  // R4
    {16'h7E00, 16'h3C00, 16'h7E00, 4'h0},  // R3
    {16'h7C01, 16'h3C00, 16'h7E01, 4'h1},  // R3
    {16'h3C00, 16'h7D00, 16'h7F00, 4'h1},  // R3
    {16'h7BFF, 16'h4000, 16'h7C00, 4'hA},  // R5
    {16'h7BFF, 16'h3C00, 16'h7BFF, 4'h0},  // R1
    {16'h0001, 16'h3C00, 16'h0001, 4'h0},  // R6
    {16'h0001, 16'h3800, 16'h0000, 4'hC},  // R6
    {16'h0003, 16'h3800, 16'h0002, 4'hC},  // R6
    {16'h0400, 16'h3800, 16'h0200, 4'h0},  // R6
    {16'h3C01, 16'h3C01, 16'h3C02, 4'h8},  // R1
    {16'h3C01, 16'h3E00, 16'h3E02, 4'h8},  // R1 tie to even
    {16'h0200, 16'h4800, 16'h0C00, 4'h0},  // R6
    {16'hFC00, 16'hFC00, 16'h7C00, 4'h0},  // R4
    {16'h7E00, 16'h7C01, 16'h7E00, 4'h1},  // R3
    {16'h7C00, 16'h0000, 16'h4000, 4'h0}   // R2
  };

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [127:0] a, input logic [127:0] b,
                       input logic w, input logic s, input logic m, input logic [3:0] t);
    @(negedge clk);
    srcA = a; srcB = b; wideSel = w; scalarMode = s; mergeEn = m; trapEn = t;
    reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  initial begin
    #4_000_000;
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [127:0] a, b, e;
    logic [3:0]   fOr;
    repeat (3) @(negedge clk);
    chk("R11 reset valid", {127'b0, rspValid}, 128'h0);
    chk("R11 reset result", result, 128'h0);
    chk("R11 reset flags", {120'b0, excFlags, excTrap}, 128'h0);
    rstN = 1'b1;

    // Table walk: every lane carries the same vector, 8-lane mode
    for (int i = 0; i < NV; i++) begin
      issue({8{VEC[i][51:36]}}, {8{VEC[i][35:20]}}, 1'b1, 1'b0, 1'b0, 4'h0);
      chk($sformatf("R1-vec%0d valid R11", i), {127'b0, rspValid}, 128'h1);
      chk($sformatf("vec%0d result R1", i), result, {8{VEC[i][19:4]}});
      chk($sformatf("vec%0d flags R9", i), {124'b0, excFlags}, {124'b0, VEC[i][3:0]});
    end

    // R1 R9: distinct vectors per lane, flags ORed over lanes
    a = '0; b = '0; e = '0; fOr = '0;
    for (int l = 0; l < 8; l++) begin
      a[l*16 +: 16] = VEC[8+l][51:36];
      b[l*16 +: 16] = VEC[8+l][35:20];
      e[l*16 +: 16] = VEC[8+l][19:4];
      fOr |= VEC[8+l][3:0];
    end
    issue(a, b, 1'b1, 1'b0, 1'b0, 4'h0);
    chk("R1 mixed lanes", result, e);
    chk("R9 mixed flags", {124'b0, excFlags}, {124'b0, fOr});

    // R7 R9: narrow vector, sNaN only in inactive lanes
    issue({{4{16'h7C01}}, {4{16'h3C00}}}, {8{16'h4000}}, 1'b0, 1'b0, 1'b0, 4'h0);
    chk("R7 narrow result", result, {64'h0, {4{16'h4000}}});
    chk("R9 inactive lanes no flags", {124'b0, excFlags}, 128'h0);

    // R8: scalar without merge, sNaN in upper lanes ignored
    a = {{7{16'h7C01}}, 16'h3E00};
    issue(a, {8{16'h3E00}}, 1'b1, 1'b1, 1'b0, 4'h0);
    chk("R8 scalar zero upper", result, {112'h0, 16'h4080});
    chk("R8 scalar flags lane0 only", {124'b0, excFlags}, 128'h0);

    // R8: scalar with merge
    a = {16'h1111, 16'h2222, 16'h3333, 16'h4444, 16'h5555, 16'h6666, 16'h7777, 16'h3E00};
    issue(a, {8{16'h3E00}}, 1'b0, 1'b1, 1'b1, 4'h0);
    chk("R8 scalar merge", result, {a[127:16], 16'h4080});

    // R8: merge ignored in vector mode
    issue({8{16'h3C00}}, {8{16'h4000}}, 1'b0, 1'b0, 1'b1, 4'h0);
    chk("R8 merge ignored narrow", result, {64'h0, {4{16'h4000}}});

    // R10: invalid trapped, inexact+underflow reported as status
    issue({{7{16'h0}}, 16'h7C01}, {{7{16'h0}}, 16'h3C00}, 1'b1, 1'b0, 1'b0, 4'h1);
    chk("R10 trap invalid", {120'b0, excTrap, excFlags}, {120'b0, 4'h1, 4'h0});
    issue({8{16'h0003}}, {8{16'h3800}}, 1'b1, 1'b0, 1'b0, 4'h8);
    chk("R10 split trap/flag", {120'b0, excTrap, excFlags}, {120'b0, 4'h8, 4'h4});

    // R11: outputs hold with no request
    repeat (3) @(negedge clk);
    chk("R11 idle valid low", {127'b0, rspValid}, 128'h0);
    chk("R11 hold result", result, {8{16'h0002}});
    chk("R11 hold trap", {124'b0, excTrap}, {124'b0, 4'h8});

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule